// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block sequences one DMA channel. A transfer is a run of beats. In each beat the engine reads one item from a source address over a valid/ready read port, then writes the same item to a destination address over a valid/ready write port. A 24-bit byte counter drops by the item size after every completed write. Source and destination addresses can each step by the item size after every beat.

A run is launched by a one-shot start pulse or by a peripheral request while requests are enabled. Before any bus traffic, the engine checks the count, the item size and the address regions. In continuous mode a single trigger runs beats until the count is exhausted. In cycle-steal mode each enabled peripheral request moves exactly one beat.

Completion, a bus error or a configuration error all set the done flag, together with the matching error flag. A clear pulse removes done and every error flag together. An interrupt line follows done when interrupts are enabled. Request enable can optionally drop itself when done is set.

Top module: `dma_xfer_eng`

## Requirements
- R1: After reset, busy, done, all error flags, irq, request enable, pending and both port valids are low, and the count readback is 0xE00000.
- R2: A count write in idle with a value of at most 0x0FFFFF reads back with bits 23:20 equal to 1110b and the value in bits 19:0. A larger value reads back exactly as written.
- R3: At launch, any of the following raises a configuration error: a count above 0x0FFFFF; a zero count; a count that is not a multiple of the item size; size code 3; or bits 31:20 of either address outside the set {0x000, 0x1FF, 0x200, 0x400}. A configuration error sets done and the config error flag, and the channel never becomes busy and issues no read.
- R4: Size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes. Each completed write lowers the count by that amount. Each address with its increment enabled rises by the same amount, and an address with its increment disabled stays fixed.
- R5: Each beat reads first, then writes the exact item read. Read and write valids are never high together.
- R6: In continuous mode (steal flag 0), one trigger moves every beat until the count reaches zero.
- R7: In cycle-steal mode (steal flag 1), one beat moves per enabled peripheral request. Between beats busy stays high and no read is issued. Pending is high while an enabled request is held and no beat is in flight.
- R8: The start pulse is taken only in idle with done clear. Busy is low after the first rising edge following the pulse and high after the second. One pulse starts one run.
- R9: When the count reaches zero, done rises and busy falls on the same edge. While done is set, neither start nor a peripheral request launches a run.
- R10: A read error response ends the run at once: done and the source error flag are set, nothing is written, and the count is unchanged.
- R11: A write error response ends the run at once: done and the destination error flag are set, and the count is unchanged.
- R12: A done-clear pulse clears done and all three error flags.
- R13: With auto-off set, request enable is cleared on the edge that sets done. With auto-off clear, request enable is left unchanged.
- R14: irq is high exactly while done is set and the interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_src_addr_i | input | 32 | Source start address, loaded at launch |
| cfg_dst_addr_i | input | 32 | Destination start address, loaded at launch |
| cfg_size_i | input | 2 | Item size code: 0 byte, 1 half, 2 word |
| cfg_src_inc_i | input | 1 | Step the source address after each beat |
| cfg_dst_inc_i | input | 1 | Step the destination address after each beat |
| cfg_steal_i | input | 1 | 1 for cycle-steal mode, 0 for continuous mode |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| cfg_auto_off_i | input | 1 | Clear request enable when done is set |
| cnt_we_i | input | 1 | Byte count write strobe (idle only) |
| cnt_wdata_i | input | 24 | Byte count write value |
| rqen_we_i | input | 1 | Request enable write strobe |
| rqen_d_i | input | 1 | Request enable write value |
| start_i | input | 1 | One-shot software start |
| done_clr_i | input | 1 | Clear done and error flags |
| periph_req_i | input | 1 | Peripheral transfer request |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read address |
| rd_ready_i | input | 1 | Read accepted; data and error valid |
| rd_data_i | input | 32 | Read data |
| rd_err_i | input | 1 | Read error response |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ready_i | input | 1 | Write accepted; error valid |
| wr_err_i | input | 1 | Write error response |
| xfer_size_o | output | 2 | Item size of the current run |
| cnt_o | output | 24 | Byte count readback |
| req_en_o | output | 1 | Request enable state |
| busy_o | output | 1 | Run in progress |
| pend_o | output | 1 | Enabled request held, no beat in flight |
| done_o | output | 1 | Done flag |
| err_src_o | output | 1 | Source bus error flag |
| err_dst_o | output | 1 | Destination bus error flag |
| err_cfg_o | output | 1 | Configuration error flag |
| irq_o | output | 1 | Interrupt |

## Verification
The main function is run with several kinds of run:
- word items with both addresses stepping;
- byte items with a fixed source and a stepping destination;
- half items in cycle-steal mode, each beat paced by a separate request.

Together these separate a wrong decrement, a wrong step and a wrong address-hold choice, because each mismatch lands on a different expected write address or data word. Further runs cover the following cases:
- configuration-error runs, one per illegal cause, to show that no read ever leaves the engine;
- runs with a read error and with a write error injected, to show which flag is set and that the count is frozen;
- a retrigger while done is still set, to show the launch is blocked.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned CNT_W      = 24;
  localparam int unsigned CNT_LIM_W  = 20;
  localparam int unsigned REGION_W   = 12;
  localparam int unsigned NUM_REGION = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_WAIT = 2'd3
  } eng_state_e;

  function automatic logic [2:0] size_bytes(xfer_size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_xfer_cfg_chk.sv
module dma_xfer_cfg_chk
  import dma_xfer_pkg::*;
#(
  parameter int unsigned CNT_W_P     = CNT_W,
  parameter int unsigned CNT_LIM_W_P = CNT_LIM_W,
  parameter int unsigned REGION_W_P  = REGION_W,
  parameter int unsigned NUM_REG_P   = NUM_REGION,
  parameter logic [NUM_REG_P-1:0][REGION_W_P-1:0] REGION_TAGS =
    {12'h400, 12'h200, 12'h1FF, 12'h000}
) (
  input  logic [CNT_W_P-1:0]    cnt_i,
  input  xfer_size_e            size_i,
  input  logic [REGION_W_P-1:0] src_region_i,
  input  logic [REGION_W_P-1:0] dst_region_i,
  output logic                  bad_o
);

  logic [NUM_REG_P-1:0] src_hit, dst_hit;

  for (genvar g = 0; g < NUM_REG_P; g++) begin : g_region
    assign src_hit[g] = (src_region_i == REGION_TAGS[g]);
    assign dst_hit[g] = (dst_region_i == REGION_TAGS[g]);
  end

  logic oversize, zero_cnt, misalign, bad_size;

  always_comb begin
    oversize = |cnt_i[CNT_W_P-1:CNT_LIM_W_P];
    zero_cnt = (cnt_i == '0);
    bad_size = (size_i == SZ_RSVD);
    case (size_i)
      SZ_HALF: misalign = cnt_i[0];
      SZ_WORD: misalign = |cnt_i[1:0];
      default: misalign = 1'b0;
    endcase
    bad_o = oversize | zero_cnt | misalign | bad_size | ~|src_hit | ~|dst_hit;
  end

endmodule

// File: rtl/dma_xfer_addr.sv
module dma_xfer_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic          inc_i,
  input  logic [2:0]    step_bytes_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (load_i)            addr_q <= load_addr_i;
    else if (step_i && inc_i)   addr_q <= addr_q + AW'(step_bytes_i);
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dma_xfer_status.sv
module dma_xfer_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_cfg_i,
  input  logic set_src_i,
  input  logic set_dst_i,
  input  logic set_fin_i,
  input  logic clr_i,
  input  logic auto_off_i,
  input  logic rqen_we_i,
  input  logic rqen_d_i,
  output logic done_o,
  output logic err_src_o,
  output logic err_dst_o,
  output logic err_cfg_o,
  output logic req_en_o
);

  logic done_q, src_q, dst_q, cfg_q, rqen_q;
  logic set_done;

  assign set_done = set_cfg_i | set_src_i | set_dst_i | set_fin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      src_q  <= 1'b0;
      dst_q  <= 1'b0;
      cfg_q  <= 1'b0;
      rqen_q <= 1'b0;
    end else begin
      // set wins over clear
      if (set_done)   done_q <= 1'b1;
      else if (clr_i) done_q <= 1'b0;
      if (set_src_i)  src_q  <= 1'b1;
      else if (clr_i) src_q  <= 1'b0;
      if (set_dst_i)  dst_q  <= 1'b1;
      else if (clr_i) dst_q  <= 1'b0;
      if (set_cfg_i)  cfg_q  <= 1'b1;
      else if (clr_i) cfg_q  <= 1'b0;
      if (set_done && auto_off_i) rqen_q <= 1'b0;
      else if (rqen_we_i)         rqen_q <= rqen_d_i;
    end
  end

  assign done_o    = done_q;
  assign err_src_o = src_q;
  assign err_dst_o = dst_q;
  assign err_cfg_o = cfg_q;
  assign req_en_o  = rqen_q;

endmodule

// File: rtl/dma_xfer_eng.sv
module dma_xfer_eng
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W_P    = ADDR_W,
  parameter int unsigned DATA_W_P    = DATA_W,
  parameter int unsigned CNT_W_P     = CNT_W,
  parameter int unsigned CNT_LIM_W_P = CNT_LIM_W,
  parameter int unsigned REGION_W_P  = REGION_W,
  parameter int unsigned NUM_REG_P   = NUM_REGION,
  parameter logic [NUM_REG_P-1:0][REGION_W_P-1:0] REGION_TAGS =
    {12'h400, 12'h200, 12'h1FF, 12'h000},
  parameter logic [CNT_W_P-CNT_LIM_W_P-1:0] CNT_TAG = 4'hE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W_P-1:0]   cfg_src_addr_i,
  input  logic [ADDR_W_P-1:0]   cfg_dst_addr_i,
  input  logic [1:0]            cfg_size_i,
  input  logic                  cfg_src_inc_i,
  input  logic                  cfg_dst_inc_i,
  input  logic                  cfg_steal_i,
  input  logic                  cfg_irq_en_i,
  input  logic                  cfg_auto_off_i,
  input  logic                  cnt_we_i,
  input  logic [CNT_W_P-1:0]    cnt_wdata_i,
  input  logic                  rqen_we_i,
  input  logic                  rqen_d_i,
  input  logic                  start_i,
  input  logic                  done_clr_i,
  input  logic                  periph_req_i,
  output logic                  rd_valid_o,
  output logic [ADDR_W_P-1:0]   rd_addr_o,
  input  logic                  rd_ready_i,
  input  logic [DATA_W_P-1:0]   rd_data_i,
  input  logic                  rd_err_i,
  output logic                  wr_valid_o,
  output logic [ADDR_W_P-1:0]   wr_addr_o,
  output logic [DATA_W_P-1:0]   wr_data_o,
  input  logic                  wr_ready_i,
  input  logic                  wr_err_i,
  output logic [1:0]            xfer_size_o,
  output logic [CNT_W_P-1:0]    cnt_o,
  output logic                  req_en_o,
  output logic                  busy_o,
  output logic                  pend_o,
  output logic                  done_o,
  output logic                  err_src_o,
  output logic                  err_dst_o,
  output logic                  err_cfg_o,
  output logic                  irq_o
);

  localparam int unsigned NUM_PTR = 2;
  localparam int unsigned TAG_W   = CNT_W_P - CNT_LIM_W_P;

  eng_state_e state_q, state_d;
  xfer_size_e size_q;
  logic       steal_q, sinc_q, dinc_q, start_q;
  logic [CNT_W_P-1:0]  cnt_q;
  logic [DATA_W_P-1:0] data_q;

  logic done, req_en, cfg_bad;
  logic trig_req, launch, go, cfg_fail;
  logic rd_ok, rd_bad, wr_ok, wr_bad, last, fin;
  logic [2:0] step_b;

  // trigger and launch
  assign trig_req = req_en & periph_req_i;
  assign launch   = (state_q == ST_IDLE) & ~done & (start_q | trig_req);
  assign go       = launch & ~cfg_bad;
  assign cfg_fail = launch & cfg_bad;

  assign step_b = size_bytes(size_q);
  assign rd_ok  = (state_q == ST_RD) & rd_ready_i & ~rd_err_i;
  assign rd_bad = (state_q == ST_RD) & rd_ready_i &  rd_err_i;
  assign wr_ok  = (state_q == ST_WR) & wr_ready_i & ~wr_err_i;
  assign wr_bad = (state_q == ST_WR) & wr_ready_i &  wr_err_i;
  assign last   = (cnt_q == CNT_W_P'(step_b));
  assign fin    = wr_ok & last;

  dma_xfer_cfg_chk #(
    .CNT_W_P     (CNT_W_P),
    .CNT_LIM_W_P (CNT_LIM_W_P),
    .REGION_W_P  (REGION_W_P),
    .NUM_REG_P   (NUM_REG_P),
    .REGION_TAGS (REGION_TAGS)
  ) u_cfg_chk (
    .cnt_i        (cnt_q),
    .size_i       (xfer_size_e'(cfg_size_i)),
    .src_region_i (cfg_src_addr_i[ADDR_W_P-1 -: REGION_W_P]),
    .dst_region_i (cfg_dst_addr_i[ADDR_W_P-1 -: REGION_W_P]),
    .bad_o        (cfg_bad)
  );

  // source (0) and destination (1) address pointers
  logic [NUM_PTR-1:0][ADDR_W_P-1:0] ptr_init, ptr_addr;
  logic [NUM_PTR-1:0]               ptr_inc;

  assign ptr_init[0] = cfg_src_addr_i;
  assign ptr_init[1] = cfg_dst_addr_i;
  assign ptr_inc[0]  = sinc_q;
  assign ptr_inc[1]  = dinc_q;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    dma_xfer_addr #(.AW(ADDR_W_P)) u_addr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (go),
      .load_addr_i  (ptr_init[g]),
      .step_i       (wr_ok),
      .inc_i        (ptr_inc[g]),
      .step_bytes_i (step_b),
      .addr_o       (ptr_addr[g])
    );
  end

  dma_xfer_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_cfg_i  (cfg_fail),
    .set_src_i  (rd_bad),
    .set_dst_i  (wr_bad),
    .set_fin_i  (fin),
    .clr_i      (done_clr_i),
    .auto_off_i (cfg_auto_off_i),
    .rqen_we_i  (rqen_we_i),
    .rqen_d_i   (rqen_d_i),
    .done_o     (done),
    .err_src_o  (err_src_o),
    .err_dst_o  (err_dst_o),
    .err_cfg_o  (err_cfg_o),
    .req_en_o   (req_en)
  );

  // channel sequencer
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go) state_d = ST_RD;
      ST_RD:   if (rd_ready_i) state_d = rd_err_i ? ST_IDLE : ST_WR;
      ST_WR: begin
        if (wr_ready_i) begin
          if (wr_err_i || last) state_d = ST_IDLE;
          else if (steal_q)     state_d = ST_WAIT;
          else                  state_d = ST_RD;
        end
      end
      ST_WAIT: if (trig_req) state_d = ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      steal_q <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go) begin
        size_q  <= xfer_size_e'(cfg_size_i);
        steal_q <= cfg_steal_i;
        sinc_q  <= cfg_src_inc_i;
        dinc_q  <= cfg_dst_inc_i;
      end
    end
  end

  // self-clearing start bit: consumed on the launch edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       start_q <= 1'b0;
    else if (launch)                                   start_q <= 1'b0;
    else if (start_i && state_q == ST_IDLE && !done)   start_q <= 1'b1;
  end

  // byte counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       cnt_q <= '0;
    else if (cnt_we_i && state_q == ST_IDLE && !launch) cnt_q <= cnt_wdata_i;
    else if (wr_ok)                                    cnt_q <= cnt_q - CNT_W_P'(step_b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (rd_ok) data_q <= rd_data_i;
  end

  logic cnt_in_range;
  assign cnt_in_range = ~|cnt_q[CNT_W_P-1:CNT_LIM_W_P];

  always_comb begin
    cnt_o = cnt_q;
    if (cnt_in_range) cnt_o = {TAG_W'(CNT_TAG), cnt_q[CNT_LIM_W_P-1:0]};
  end

  assign rd_valid_o  = (state_q == ST_RD);
  assign rd_addr_o   = ptr_addr[0];
  assign wr_valid_o  = (state_q == ST_WR);
  assign wr_addr_o   = ptr_addr[1];
  assign wr_data_o   = data_q;
  assign xfer_size_o = size_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign pend_o      = trig_req & (state_q != ST_RD) & (state_q != ST_WR);
  assign done_o      = done;
  assign req_en_o    = req_en;
  assign irq_o       = done & cfg_irq_en_i;

endmodule

// File: rtl/dma_xfer_eng_chk.sv
module dma_xfer_eng_chk #(
  parameter int unsigned CNT_W_P = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_auto_off_i,
  input logic               rd_valid_o,
  input logic               rd_ready_i,
  input logic               rd_err_i,
  input logic               wr_valid_o,
  input logic               wr_ready_i,
  input logic [CNT_W_P-1:0] cnt_o,
  input logic               req_en_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_src_o,
  input logic               err_dst_o,
  input logic               err_cfg_o,
  input logic               irq_o
);

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o)); // R5

  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> $past(rd_valid_o && rd_ready_i && !rd_err_i)); // R5

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o); // R9

  AST_CFG_NEVER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_cfg_o) |-> (!busy_o && !$past(busy_o))); // R3

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(wr_valid_o && wr_ready_i)) |-> $stable(cnt_o)); // R4

  AST_AUTO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && $past(cfg_auto_off_i)) |-> !req_en_o); // R13

  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o); // R14

  AST_ONE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_src_o, err_dst_o, err_cfg_o})); // R10

endmodule

bind dma_xfer_eng dma_xfer_eng_chk #(.CNT_W_P(CNT_W_P)) u_eng_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_auto_off_i (cfg_auto_off_i),
  .rd_valid_o     (rd_valid_o),
  .rd_ready_i     (rd_ready_i),
  .rd_err_i       (rd_err_i),
  .wr_valid_o     (wr_valid_o),
  .wr_ready_i     (wr_ready_i),
  .cnt_o          (cnt_o),
  .req_en_o       (req_en_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .err_src_o      (err_src_o),
  .err_dst_o      (err_dst_o),
  .err_cfg_o      (err_cfg_o),
  .irq_o          (irq_o)
);

// File: tb/dma_xfer_eng_tb_top.sv
module dma_xfer_eng_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [1:0]  cfg_size = '0;
  logic        cfg_sinc = 0, cfg_dinc = 0, cfg_steal = 0, cfg_irq_en = 0, cfg_auto_off = 0;
  logic        cnt_we = 0;
  logic [23:0] cnt_wdata = '0;
  logic        rqen_we = 0, rqen_d = 0, start = 0, done_clr = 0, preq = 0;
  logic        rd_valid, rd_ready = 0, rd_err = 0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        wr_valid, wr_ready = 0, wr_err = 0;
  logic [31:0] wr_addr, wr_data;
  logic [1:0]  xsize;
  logic [23:0] cnt_rb;
  logic        req_en, busy, pend, done, e_src, e_dst, e_cfg, irq;

  int n_chk = 0, n_err = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit rd_err_mode = 0, wr_err_mode = 0, finished = 0;
  logic [63:0] exp_q[$];

  always #4 clk = ~clk;

  dma_xfer_eng dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_src_addr_i(cfg_src), .cfg_dst_addr_i(cfg_dst), .cfg_size_i(cfg_size),
    .cfg_src_inc_i(cfg_sinc), .cfg_dst_inc_i(cfg_dinc), .cfg_steal_i(cfg_steal),
    .cfg_irq_en_i(cfg_irq_en), .cfg_auto_off_i(cfg_auto_off),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata), .rqen_we_i(rqen_we), .rqen_d_i(rqen_d),
    .start_i(start), .done_clr_i(done_clr), .periph_req_i(preq),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready),
    .rd_data_i(rd_data), .rd_err_i(rd_err),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ready_i(wr_ready), .wr_err_i(wr_err),
    .xfer_size_o(xsize), .cnt_o(cnt_rb), .req_en_o(req_en), .busy_o(busy),
    .pend_o(pend), .done_o(done), .err_src_o(e_src), .err_dst_o(e_dst),
    .err_cfg_o(e_cfg), .irq_o(irq)
  );

  function automatic logic [31:0] pat(logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_run(logic [31:0] src, logic [31:0] dst, int bytes, int cnt, bit si, bit di);
    for (int i = 0; i < cnt / bytes; i++)
      exp_q.push_back({dst + (di ? 32'(i * bytes) : 32'd0),
                       pat(src + (si ? 32'(i * bytes) : 32'd0))});
  endtask

  // memory responder and write monitor
  initial forever begin
    @(negedge clk);
    if (rd_ready) begin
      rd_ready = 0; rd_err = 0;
    end else if (rd_valid) begin
      rd_ready = 1; rd_err = rd_err_mode; rd_data = pat(rd_addr); rd_cnt++;
    end
    if (wr_ready) begin
      wr_ready = 0; wr_err = 0;
    end else if (wr_valid) begin
      wr_ready = 1; wr_err = wr_err_mode;
      if (!wr_err_mode) begin
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk("R5 unexpected write", wr_addr, 32'hFFFF_FFFF);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk("R4 write address", wr_addr, e[63:32]);
          chk("R5 write data", wr_data, e[31:0]);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cnt(logic [23:0] v);
    cnt_wdata = v; cnt_we = 1; tick(); cnt_we = 0;
  endtask

  task automatic pulse_start();
    start = 1; tick(); start = 0;
  endtask

  task automatic clear_done();
    done_clr = 1; tick(); done_clr = 0;
  endtask

  task automatic set_rqen(logic v);
    rqen_d = v; rqen_we = 1; tick(); rqen_we = 0;
  endtask

  task automatic wait_done(string req);
    int k = 0;
    while (!done && k < 400) begin tick(); k++; end
    chk({req, " done reached"}, 32'(done), 32'd1);
  endtask

  task automatic cfg_err_case(string req, logic [31:0] s, logic [31:0] d, logic [1:0] sz, logic [23:0] c);
    int r0;
    cfg_src = s; cfg_dst = d; cfg_size = sz; write_cnt(c);
    r0 = rd_cnt;
    pulse_start();
    chk({req, " busy stays low"}, 32'(busy), 32'd0);
    wait_done(req);
    chk({req, " config error"}, 32'(e_cfg), 32'd1);
    chk({req, " no read"}, 32'(rd_cnt), 32'(r0));
    chk({req, " busy low"}, 32'(busy), 32'd0);
    clear_done();
  endtask

  initial begin
    int r0, w0;
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 errors", {29'd0, e_src, e_dst, e_cfg}, 0);
    chk("R1 irq/req_en/pend", {29'd0, irq, req_en, pend}, 0);
    chk("R1 valids", {30'd0, rd_valid, wr_valid}, 0);
    chk("R1 count readback", 32'(cnt_rb), 32'h00E0_0000);

    // R2 readback encoding
    write_cnt(24'h000010);
    chk("R2 in-range readback", 32'(cnt_rb), 32'h00E0_0010);
    write_cnt(24'h100000);
    chk("R2 oversize readback", 32'(cnt_rb), 32'h0010_0000);

    // R3 configuration errors, each cleared by R12 pulse
    cfg_err_case("R3 oversize", 32'h2000_0000, 32'h2000_0100, 2'd2, 24'h100000);
    chk("R12 errors cleared", {28'd0, done, e_src, e_dst, e_cfg}, 0);
    cfg_err_case("R3 bad src region", 32'h3000_0000, 32'h2000_0100, 2'd2, 24'd8);
    cfg_err_case("R3 bad dst region", 32'h2000_0000, 32'h1FE0_0000, 2'd2, 24'd8);
    cfg_err_case("R3 misaligned count", 32'h2000_0000, 32'h2000_0100, 2'd2, 24'd6);
    cfg_err_case("R3 zero count", 32'h2000_0000, 32'h2000_0100, 2'd0, 24'd0);
    cfg_err_case("R3 reserved size", 32'h2000_0000, 32'h2000_0100, 2'd3, 24'd8);

    // R6 continuous word run, R8 start timing, R14 irq
    cfg_src = 32'h2000_0100; cfg_dst = 32'h4000_0800; cfg_size = 2'd2;
    cfg_sinc = 1; cfg_dinc = 1; cfg_steal = 0; cfg_irq_en = 1;
    write_cnt(24'd16);
    push_run(cfg_src, cfg_dst, 4, 16, 1, 1);
    w0 = wr_cnt;
    start = 1; tick(); start = 0;
    chk("R8 busy low after first edge", 32'(busy), 0);
    tick();
    chk("R8 busy high after second edge", 32'(busy), 1);
    wait_done("R6");
    chk("R6 all beats written", 32'(wr_cnt - w0), 32'd4);
    chk("R9 busy low at done", 32'(busy), 0);
    chk("R4 count at zero", 32'(cnt_rb), 32'h00E0_0000);
    chk("R14 irq with enable", 32'(irq), 1);
    chk("R3 no config error on valid run", 32'(e_cfg), 0);

    // R9 launch blocked while done set
    r0 = rd_cnt;
    set_rqen(1);
    pulse_start();
    preq = 1; tick(8); preq = 0;
    chk("R9 no read while done", 32'(rd_cnt), 32'(r0));
    chk("R9 not busy while done", 32'(busy), 0);
    set_rqen(0);
    clear_done();
    chk("R14 irq follows done", 32'(irq), 0);

    // R4 byte run, fixed source, request-triggered, R13 auto-off clear
    cfg_src = 32'h0000_0040; cfg_dst = 32'h1FF0_0010; cfg_size = 2'd0;
    cfg_sinc = 0; cfg_dinc = 1; cfg_auto_off = 0;
    write_cnt(24'd3);
    set_rqen(1);
    push_run(cfg_src, cfg_dst, 1, 3, 0, 1);
    w0 = wr_cnt;
    preq = 1; tick(); preq = 0;
    wait_done("R4");
    chk("R4 byte beats", 32'(wr_cnt - w0), 32'd3);
    chk("R13 req_en kept without auto-off", 32'(req_en), 1);
    set_rqen(0);
    clear_done();

    // R7 cycle-steal half run with auto-off
    cfg_src = 32'h2000_0200; cfg_dst = 32'h2000_0300; cfg_size = 2'd1;
    cfg_sinc = 1; cfg_dinc = 1; cfg_steal = 1; cfg_auto_off = 1; cfg_irq_en = 0;
    write_cnt(24'd4);
    set_rqen(1);
    push_run(cfg_src, cfg_dst, 2, 4, 1, 1);
    r0 = rd_cnt; w0 = wr_cnt;
    preq = 1; tick(); preq = 0;
    tick(10);
    chk("R7 one beat per request", 32'(rd_cnt - r0), 32'd1);
    chk("R7 busy between beats", 32'(busy), 1);
    chk("R7 count after one beat", 32'(cnt_rb), 32'h00E0_0002);
    chk("R7 no pending without request", 32'(pend), 0);
    preq = 1; #1;
    chk("R7 pending with held request", 32'(pend), 1);
    tick(); preq = 0;
    wait_done("R7");
    chk("R7 second beat", 32'(wr_cnt - w0), 32'd2);
    chk("R13 auto-off clears req_en", 32'(req_en), 0);
    chk("R14 irq off when disabled", 32'(irq), 0);
    clear_done();
    cfg_steal = 0; cfg_auto_off = 0;

    // R10 read error
    cfg_src = 32'h2000_0000; cfg_dst = 32'h2000_0400; cfg_size = 2'd2;
    write_cnt(24'd8);
    w0 = wr_cnt; rd_err_mode = 1;
    pulse_start();
    wait_done("R10");
    rd_err_mode = 0;
    chk("R10 source error", {30'd0, e_src, e_dst}, 32'd2);
    chk("R10 no write", 32'(wr_cnt - w0), 0);
    chk("R10 count unchanged", 32'(cnt_rb), 32'h00E0_0008);
    clear_done();
    chk("R12 source error cleared", 32'(e_src), 0);

    // R11 write error
    wr_err_mode = 1;
    pulse_start();
    wait_done("R11");
    tick(2);
    wr_err_mode = 0;
    chk("R11 destination error", {30'd0, e_src, e_dst}, 32'd1);
    chk("R11 count unchanged", 32'(cnt_rb), 32'h00E0_0008);
    chk("R11 not busy", 32'(busy), 0);
    clear_done();
    chk("R12 done cleared", {30'd0, done, e_dst}, 0);

    chk("R5 scoreboard drained", 32'(exp_q.size()), 0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule